// File: doc/BRIEF.md
# Power-Aware Interrupt Core Selector

This block decides which processor core receives a re-routable interrupt. When the request strobe is high, it looks at the cores that may take the interrupt. For each of those cores it weighs the current idle depth and whether the core is asking for a turbo performance level. It then names exactly one of them as the target.

A mode input sets the bias. Under the power bias, the interrupt is steered to a core that is already awake, so sleeping cores stay asleep. Under the performance bias, the interrupt goes to a core that is idle, so busy cores are not disturbed, and a wake request is raised for that core.

The decision is registered. It appears one clock after the strobe and is held until the next strobe. An empty eligibility mask produces an error flag instead of a target.

Top module: `irq_core_picker`

## Requirements
- R1: Only a core whose bit is set in `elig_mask` at the strobe can be named in `target_onehot`. Bit i of each per-core vector refers to core i, and core i's idle code sits at `idle_state[3*i+2:3*i]`.
- R2: The outputs change only on the rising clock edge at which `req_valid` is sampled high. They are visible from that edge onward and are held while `req_valid` is low, whatever the other inputs do.
- R3: With `perf_mode` low (power bias), the target is the eligible core with the lowest idle code. Code 0 means active, 1 shallow halt, 3 mid sleep and 6 deep power-gated sleep, and a larger code means a deeper state.
- R4: With `perf_mode` low, among eligible cores sharing the lowest code, a core with `turbo_req` low is preferred over one with `turbo_req` high.
- R5: With `perf_mode` high (performance bias), if any eligible core has a non-zero idle code, the target is the one with the smallest non-zero code.
- R6: With `perf_mode` high and every eligible core active, a core with `turbo_req` low is preferred; only if all of them request turbo is a turbo core chosen.
- R7: Any tie left after the rules above goes to the lowest core index.
- R8: `wake_req` is high exactly when a target is named and that core's idle code at the strobe was non-zero.
- R9: An all-zero `elig_mask` at the strobe sets `no_target` to 1, with `target_onehot` all zero and `wake_req` 0. Otherwise `no_target` is 0 and `target_onehot` has exactly one bit set.
- R10: While `rst_n` is low at a rising edge, all outputs clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Interrupt request strobe, one cycle per decision |
| elig_mask | input | NUM_CORES | Cores allowed to take this interrupt |
| idle_state | input | 3*NUM_CORES | Per-core idle depth code |
| turbo_req | input | NUM_CORES | Per-core turbo request |
| perf_mode | input | 1 | 0 = power bias, 1 = performance bias |
| target_onehot | output | NUM_CORES | Chosen core, one-hot |
| wake_req | output | 1 | Chosen core is asleep and must be woken |
| no_target | output | 1 | No eligible core for the last request |

## Verification
The properties are written on the assumption that the mask, idle codes, turbo bits and mode are stable and valid at the edge where the strobe is sampled. They also assume the strobe is never X after reset. Idle codes may take any 3-bit value, not only the four named ones, so the rules are checked over the whole code space.

The bench changes every input only at the falling edge and raises the strobe for a single cycle at a time. Between strobes it scrambles the data inputs, to show that the held result ignores them. The directed cases cover the bias rules and the tie rules; a long run of pseudo-random masks, codes and modes follows, including empty masks.

// File: rtl/irq_pick_pkg.sv
`timescale 1ns/1ps
// Shared types for the interrupt core selector.
// Assumes idle codes are 3 bits and that a larger code means a deeper state.
package irq_pick_pkg;
    localparam int STATE_W = 3;
    localparam int KEY_W   = STATE_W + 2;
    typedef logic [STATE_W-1:0] cstate_t;
    typedef logic [KEY_W-1:0]   key_t;
    localparam cstate_t ST_ACTIVE = '0;
    // Performance-bias keys for awake cores; they rank after every sleeping core.
    localparam key_t KEY_AWAKE_COOL  = key_t'(1 << (KEY_W - 2));
    localparam key_t KEY_AWAKE_TURBO = key_t'((1 << (KEY_W - 2)) + 1);
endpackage

// File: rtl/irq_key_gen.sv
`timescale 1ns/1ps
// Builds a per-core rank key, where a smaller key means a better target.
// Power bias:       {0, code, turbo}
// Performance bias: sleeping cores {00, code}; awake cores rank after them,
//                   with a non-turbo core ahead of a turbo core.
// Assumes the caller masks out ineligible cores separately.
module irq_key_gen
    import irq_pick_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [NUM_CORES*STATE_W-1:0] idle_state,
    input  logic [NUM_CORES-1:0]         turbo_req,
    input  logic                         perf_mode,
    output logic [NUM_CORES*KEY_W-1:0]   keys_flat
);
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        cstate_t st;
        key_t    key;
        assign st = idle_state[i*STATE_W +: STATE_W];
        // One rank key per core, chosen by the bias mode.
        always_comb begin
            if (!perf_mode) begin
                key = {1'b0, st, turbo_req[i]};
            end else if (st == ST_ACTIVE) begin
                key = turbo_req[i] ? KEY_AWAKE_TURBO : KEY_AWAKE_COOL;
            end else begin
                key = {2'b00, st};
            end
        end
        assign keys_flat[i*KEY_W +: KEY_W] = key;
    end
endmodule

// File: rtl/irq_min_pick.sv
`timescale 1ns/1ps
// Finds the valid entry with the smallest key; on equal keys the lowest index wins.
// It is a linear chain, so the logic depth grows with NUM_CORES, which is
// acceptable for small core counts.
module irq_min_pick #(
    parameter int NUM_CORES = 4,
    parameter int KEY_W     = 5
) (
    input  logic [NUM_CORES*KEY_W-1:0] keys_flat,
    input  logic [NUM_CORES-1:0]       valid,
    output logic [NUM_CORES-1:0]       win_onehot,
    output logic                       any_valid
);
    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    logic [KEY_W-1:0] best_key [NUM_CORES+1];
    logic [IDX_W-1:0] best_idx [NUM_CORES+1];
    logic             best_vld [NUM_CORES+1];

    assign best_key[0] = '1;
    assign best_idx[0] = '0;
    assign best_vld[0] = 1'b0;

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_stage
        logic [KEY_W-1:0] k;
        logic             take;
        assign k = keys_flat[i*KEY_W +: KEY_W];
        // Replace the running best only on a strictly smaller key.
        assign take = valid[i] && (!best_vld[i] || (k < best_key[i]));
        assign best_key[i+1] = take ? k : best_key[i];
        assign best_idx[i+1] = take ? IDX_W'(i) : best_idx[i];
        assign best_vld[i+1] = best_vld[i] | valid[i];
    end

    for (genvar j = 0; j < NUM_CORES; j++) begin : g_dec
        assign win_onehot[j] = best_vld[NUM_CORES] && (best_idx[NUM_CORES] == IDX_W'(j));
    end

    assign any_valid = best_vld[NUM_CORES];
endmodule

// File: rtl/irq_core_picker.sv
`timescale 1ns/1ps
// Top of the power-aware interrupt core selector.
// On each req_valid it ranks the eligible cores and registers a one-hot
// target, a wake flag and an empty-mask flag. The result is held until the
// next request. Assumes the inputs are stable at the edge where req_valid
// is sampled.
module irq_core_picker
    import irq_pick_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [NUM_CORES-1:0]         elig_mask,
    input  logic [NUM_CORES*STATE_W-1:0] idle_state,
    input  logic [NUM_CORES-1:0]         turbo_req,
    input  logic                         perf_mode,
    output logic [NUM_CORES-1:0]         target_onehot,
    output logic                         wake_req,
    output logic                         no_target
);
    logic [NUM_CORES*KEY_W-1:0] keys_flat;
    logic [NUM_CORES-1:0]       win_onehot;
    logic                       any_valid;
    logic [NUM_CORES-1:0]       asleep;
    logic                       win_asleep;

    irq_key_gen #(.NUM_CORES(NUM_CORES)) u_keys (
        .idle_state (idle_state),
        .turbo_req  (turbo_req),
        .perf_mode  (perf_mode),
        .keys_flat  (keys_flat)
    );

    irq_min_pick #(.NUM_CORES(NUM_CORES), .KEY_W(KEY_W)) u_pick (
        .keys_flat  (keys_flat),
        .valid      (elig_mask),
        .win_onehot (win_onehot),
        .any_valid  (any_valid)
    );

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_sleep
        assign asleep[i] = (idle_state[i*STATE_W +: STATE_W] != ST_ACTIVE);
    end

    // The winner needs waking when its idle code is non-zero.
    assign win_asleep = |(win_onehot & asleep);

    // Capture the decision on a request; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_onehot <= '0;
            wake_req      <= 1'b0;
            no_target     <= 1'b0;
        end else if (req_valid) begin
            target_onehot <= win_onehot;
            wake_req      <= win_asleep;
            no_target     <= !any_valid;
        end
    end
endmodule

// File: rtl/irq_core_picker_chk.sv
`timescale 1ns/1ps
// Assertion checker for irq_core_picker, attached with bind.
// Assumes the inputs are valid at the edge where req_valid is sampled.
module irq_core_picker_chk
    import irq_pick_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic [NUM_CORES-1:0]         elig_mask,
    input logic [NUM_CORES*STATE_W-1:0] idle_state,
    input logic                         perf_mode,
    input logic [NUM_CORES-1:0]         target_onehot,
    input logic                         wake_req,
    input logic                         no_target
);
    logic [NUM_CORES-1:0] sleeping;
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_s
        assign sleeping[i] = |idle_state[i*STATE_W +: STATE_W];
    end

    // R1: the target lies inside the mask sampled with the request.
    p_target_eligible_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((target_onehot & ~$past(elig_mask)) == '0));

    // R2: without a request, the outputs hold.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(target_onehot) && $stable(wake_req) && $stable(no_target)));

    // R3: under power bias with an awake eligible core, nothing is woken.
    p_power_no_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !perf_mode && ((elig_mask & ~sleeping) != '0)) |=> !wake_req);

    // R5: under performance bias with a sleeping eligible core, it is woken.
    p_perf_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && perf_mode && ((elig_mask & sleeping) != '0)) |=> wake_req);

    // R8: the wake flag matches the sleep state of the chosen core.
    p_wake_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (wake_req == ((target_onehot & $past(sleeping)) != '0)));

    // R9: an empty mask gives the error flag and no target.
    p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (elig_mask == '0)) |=> (no_target && (target_onehot == '0) && !wake_req));

    // R9: a non-empty mask gives exactly one target.
    p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (elig_mask != '0)) |=> (!no_target && ($countones(target_onehot) == 1)));

    // R9: the target is never multi-hot.
    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(target_onehot));
endmodule

bind irq_core_picker irq_core_picker_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .elig_mask     (elig_mask),
    .idle_state    (idle_state),
    .perf_mode     (perf_mode),
    .target_onehot (target_onehot),
    .wake_req      (wake_req),
    .no_target     (no_target)
);

// File: tb/irq_core_picker_tb.sv
`timescale 1ns/1ps
// Scoreboard bench for irq_core_picker.
module irq_core_picker_tb;
    localparam int N  = 4;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [N-1:0]  elig_mask = '0;
    logic [N*SW-1:0] idle_state = '0;
    logic [N-1:0]  turbo_req = '0;
    logic          perf_mode = 1'b0;
    logic [N-1:0]  target_onehot;
    logic          wake_req;
    logic          no_target;

    typedef struct {
        logic [N-1:0] tgt;
        logic         wake;
        logic         err;
        string        tag;
    } exp_t;

    exp_t q[$];
    exp_t last_exp;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #4 clk = ~clk;

    irq_core_picker #(.NUM_CORES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .elig_mask(elig_mask),
        .idle_state(idle_state), .turbo_req(turbo_req), .perf_mode(perf_mode),
        .target_onehot(target_onehot), .wake_req(wake_req), .no_target(no_target)
    );

    // Reference model written straight from the requirements; returns -1 when no core is eligible.
    function automatic int ref_pick(logic [N-1:0] m, logic [N*SW-1:0] s,
                                    logic [N-1:0] t, logic pm);
        int best = -1;
        if (!pm) begin
            for (int i = 0; i < N; i++) begin
                if (m[i]) begin
                    if (best < 0) best = i;
                    else if (s[i*SW +: SW] < s[best*SW +: SW]) best = i;
                    else if (s[i*SW +: SW] == s[best*SW +: SW] && !t[i] && t[best]) best = i;
                end
            end
            return best;
        end
        for (int i = 0; i < N; i++)
            if (m[i] && s[i*SW +: SW] != 0)
                if (best < 0 || s[i*SW +: SW] < s[best*SW +: SW]) best = i;
        if (best >= 0) return best;
        for (int i = 0; i < N; i++) if (m[i] && !t[i]) return i;
        for (int i = 0; i < N; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic check(exp_t e, string where);
        n_checks++;
        if (target_onehot !== e.tgt || wake_req !== e.wake || no_target !== e.err) begin
            n_fail++;
            $display("FAIL %s %s: got tgt=%b wake=%b err=%b, expected tgt=%b wake=%b err=%b",
                     e.tag, where, target_onehot, wake_req, no_target, e.tgt, e.wake, e.err);
        end
    endtask

    // Driver: one strobe cycle per request, expected result pushed to the scoreboard.
    task automatic do_req(logic [N-1:0] m, logic [N*SW-1:0] s, logic [N-1:0] t,
                          logic pm, string tag);
        exp_t e;
        int   w;
        @(negedge clk);
        elig_mask = m; idle_state = s; turbo_req = t; perf_mode = pm; req_valid = 1'b1;
        w = ref_pick(m, s, t, pm);
        e.tgt  = (w < 0) ? '0 : N'(1) << w;
        e.wake = (w >= 0) && (s[w*SW +: SW] != 0);
        e.err  = (w < 0);
        e.tag  = tag;
        q.push_back(e);
        last_exp = e;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: a result is due at the falling edge after a sampled strobe.
    initial begin
        forever begin
            bit seen;
            @(posedge clk);
            seen = (req_valid === 1'b1) && (rst_n === 1'b1);
            @(negedge clk);
            if (seen) begin
                if (q.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R2: result with empty scoreboard, got tgt=%b expected none", target_onehot);
                end else begin
                    check(q.pop_front(), "scoreboard");
                end
            end
        end
    end

    // Scramble the data inputs without a strobe and confirm the outputs hold (R2).
    task automatic hold_check();
        @(negedge clk);
        elig_mask = ~elig_mask; idle_state = ~idle_state; turbo_req = ~turbo_req; perf_mode = ~perf_mode;
        @(negedge clk);
        last_exp.tag = "R2";
        check(last_exp, "hold");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got hang, expected completion");
        finish_run();
    end

    initial begin
        exp_t z;
        // R10: drive the strobe during reset; outputs stay zero.
        req_valid = 1'b1; elig_mask = 4'b1111; idle_state = {3'd6, 3'd6, 3'd6, 3'd6};
        repeat (3) @(negedge clk);
        z.tgt = '0; z.wake = 1'b0; z.err = 1'b0; z.tag = "R10";
        check(z, "reset");
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(z, "after reset");

        // R3: power bias sends the interrupt to the awake core over the deep sleeper.
        do_req(4'b0011, {3'd0, 3'd0, 3'd0, 3'd6}, 4'b0000, 1'b0, "R3");
        hold_check();
        // R5/R8: performance bias picks the deep sleeper and wakes it.
        do_req(4'b0011, {3'd0, 3'd0, 3'd0, 3'd6}, 4'b0000, 1'b1, "R5 R8");
        hold_check();
        // R4: equal codes, the non-turbo core wins.
        do_req(4'b1111, {3'd1, 3'd1, 3'd1, 3'd1}, 4'b0101, 1'b0, "R4");
        // R6: all awake, the first non-turbo core wins.
        do_req(4'b1111, {3'd0, 3'd0, 3'd0, 3'd0}, 4'b0011, 1'b1, "R6");
        // R6/R7: all awake and turbo, the lowest index wins.
        do_req(4'b1111, {3'd0, 3'd0, 3'd0, 3'd0}, 4'b1111, 1'b1, "R6 R7");
        // R9: empty mask.
        do_req(4'b0000, {3'd0, 3'd0, 3'd0, 3'd0}, 4'b0000, 1'b0, "R9");
        hold_check();
        // R1: the only eligible core is the deep sleeper.
        do_req(4'b1000, {3'd6, 3'd0, 3'd0, 3'd0}, 4'b0000, 1'b0, "R1");
        // R5: the shallowest non-zero code wins under performance bias.
        do_req(4'b1111, {3'd0, 3'd1, 3'd3, 3'd6}, 4'b0000, 1'b1, "R5");
        // R7: identical keys, the lowest eligible index wins.
        do_req(4'b0110, {3'd3, 3'd3, 3'd3, 3'd3}, 4'b0000, 1'b0, "R7");
        // R3: the lowest code wins regardless of turbo.
        do_req(4'b1110, {3'd3, 3'd1, 3'd6, 3'd0}, 4'b0100, 1'b0, "R3");

        // R1: pseudo-random sweep over masks, codes, turbo bits and modes.
        for (int k = 0; k < 300; k++) begin
            do_req(N'($urandom), (N*SW)'($urandom), N'($urandom), 1'($urandom), "R1 random");
            if (k % 50 == 0) hold_check();
        end

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R2: got %0d pending results, expected 0", q.size());
        end
        finish_run();
    end
endmodule